// File: doc/BRIEF.md
# Bridge Memory-Read Prefetch Controller

This block sits behind the target side of a bridge from a downstream parallel bus to an upstream link. For every memory read the downstream bus decodes, it sizes the upstream fetch. It sorts the read into one of three kinds: plain read, read-line or read-multiple. It applies the prefetch enables for that kind and then decides two things: whether the 64-bit transfer is acknowledged, and whether the upstream request is one dword, two dwords or a series of 64-byte lines.

When prefetch is enabled and the master signals a burst, the block fetches the rest of the addressed line. It then issues a configurable number of speculative full-line fetches. As the master drains each line, it can add one more speculative line. The block keeps an age-ordered record of up to eight allocated lines, and each line carries a tag saying whether a master really asked for it.

A new address phase that lands inside a buffered line promotes that line to requested. A new address phase that misses every buffered line clears the whole record before fetching again. The decision is made from a decoded descriptor and configuration inputs. The bus pin state machine and the data storage sit outside this block.

Top module: `readPrefetchCtl`

## Requirements
- R1: Prefetch is enabled for a read when the issuing master's bit in `cfgMasterPfEn` is set. For a plain read (`reqKind` 0 or 3), `cfgPlainPfEn` must also be set. Read-line (`reqKind` 1) and read-multiple (`reqKind` 2) need only the master bit.
- R2: A plain read without prefetch issues one upstream request of 1 dword and leaves `ack64` low, whatever `req64` says.
- R3: Two kinds of read follow the same width rule: a read-line or read-multiple without prefetch, and any read that is not a burst. With `req64` high, such a read raises `ack64` and requests 2 dwords. With `req64` low, it requests 1 dword. `ack64` is valid from the cycle after acceptance until the next acceptance.
- R4: A read is a burst when `reqBurst` is high or when `reqStopEarly` is high.
- R5: A prefetch-enabled burst that misses first requests the dword-aligned request address, with a length of 16 minus address bits [5:2] dwords. This length ends the request at the line boundary.
- R6: After that first request, the block issues N full-line requests of 16 dwords at the following consecutive 64-byte line bases. N comes from `cfgInitMult` for read-multiple and from `cfgInitLine` for the other kinds.
- R7: When `lineDone` retires a buffered line during a prefetching burst, one more full line after the last allocated line is requested. This happens only if the continuous enable for the kind is set: `cfgContMult` for read-multiple, and `cfgContLine` for the other kinds.
- R8: A read that is not both prefetch-enabled and a burst allocates no lines and never causes a full-line request.
- R9: `lineReqMask` bit k shows the tag of the k-th oldest line: 1 for requested, 0 for speculative. The first line of a burst is requested and the later lines are speculative. Retiring lines with `lineDone` promotes no line.
- R10: A new accepted read whose address falls in a buffered line sets that line's tag to requested. It keeps all lines and issues no upstream request.
- R11: A new accepted read that misses all buffered lines empties the record, so `lineCount` is 0 in the following cycle.
- R12: `lineCount` never exceeds 8, and it rises by one for each line request accepted upstream.
- R13: If `lineDone` retires the last allocated line and no further line is due, `disconnect` pulses high for one cycle, one cycle later.
- R14: While `upValid` is high and `upReady` is low, `upValid`, `upAddr` and `upDw` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Decoded read descriptor present |
| reqReady | output | 1 | Block can accept a descriptor |
| reqKind | input | 2 | 0/3 plain read, 1 read-line, 2 read-multiple |
| reqAddr | input | 32 | Byte address of the read |
| reqMaster | input | 3 | Index of the issuing master |
| req64 | input | 1 | Master asks for a 64-bit transfer |
| reqBurst | input | 1 | Frame still asserted when initiator-ready first asserted |
| reqStopEarly | input | 1 | Stop was seen before initiator-ready |
| lineDone | input | 1 | Master finished transferring the oldest buffered line |
| cfgMasterPfEn | input | 8 | Per-master prefetch enables |
| cfgPlainPfEn | input | 1 | Extra enable for plain-read prefetch |
| cfgInitLine | input | 3 | Speculative line count for read-line and plain |
| cfgInitMult | input | 3 | Speculative line count for read-multiple |
| cfgContLine | input | 1 | Continuous prefetch for read-line and plain |
| cfgContMult | input | 1 | Continuous prefetch for read-multiple |
| upValid | output | 1 | Upstream request valid |
| upReady | input | 1 | Upstream request accepted |
| upAddr | output | 32 | Upstream request address |
| upDw | output | 5 | Upstream request length in dwords |
| ack64 | output | 1 | Acknowledge of the 64-bit transfer |
| disconnect | output | 1 | One-cycle pulse: no further line available |
| lineCount | output | 4 | Number of allocated lines |
| lineReqMask | output | 8 | Requested tag per line, oldest first |

## Verification
Each result has a fixed delay. When a descriptor is accepted on a clock edge, `ack64`, a flushed `lineCount` and the first upstream request all appear one cycle later. A promotion also shows in `lineReqMask` one cycle later. A line request raises `lineCount` in the cycle after the edge where `upReady` takes it. `disconnect` and a continuous-prefetch request follow `lineDone` by one and two cycles. The bench drives inputs just after the rising edge and samples on the falling edge that follows the edge where each result is due. A scoreboard queue holds the expected upstream requests; the monitor pops one only when valid and ready are both high on that falling edge, so a stalled request is compared once.

// File: rtl/rpfPkg.sv
package rpfPkg;

  localparam logic [1:0] KIND_LINE = 2'd1;
  localparam logic [1:0] KIND_MULT = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SINGLE,
    ST_FIRST,
    ST_SPEC
  } fetchStateT;

  typedef struct packed {
    logic flush;
    logic push;
    logic pushReq;
    logic promote;
    logic pop;
  } lineStrobeT;

endpackage

// File: rtl/rpfLineTrack.sv
module rpfLineTrack
  import rpfPkg::*;
#(
  parameter int TAG_W = 26,
  parameter int MAX_LINES = 8,
  localparam int PTR_W = $clog2(MAX_LINES),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  lineStrobeT           strobe,
  input  logic [TAG_W-1:0]     pushLine,
  input  logic [TAG_W-1:0]     lookupLine,
  output logic                 hit,
  output logic [CNT_W-1:0]     lineCount,
  output logic [MAX_LINES-1:0] reqMask
);

  logic [PTR_W-1:0]     headQ;
  logic [CNT_W-1:0]     countQ;
  logic [TAG_W-1:0]     tagQ [MAX_LINES];
  logic [MAX_LINES-1:0] reqQ;
  logic [MAX_LINES-1:0] slotValid;
  logic [MAX_LINES-1:0] slotMatch;
  logic [PTR_W-1:0]     tailPtr;
  logic                 popEff;

  assign popEff    = strobe.pop && (countQ != '0);
  assign tailPtr   = headQ + PTR_W'(countQ);
  assign lineCount = countQ;
  assign hit       = |slotMatch;

  for (genvar g = 0; g < MAX_LINES; g++) begin : gSlot
    logic [PTR_W-1:0] age;
    assign age          = PTR_W'(g) - headQ;
    assign slotValid[g] = CNT_W'(age) < countQ;
    assign slotMatch[g] = slotValid[g] && (tagQ[g] == lookupLine);
  end

  for (genvar k = 0; k < MAX_LINES; k++) begin : gAge
    logic [PTR_W-1:0] slot;
    assign slot       = headQ + PTR_W'(k);
    assign reqMask[k] = (CNT_W'(k) < countQ) && reqQ[slot];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ  <= '0;
      countQ <= '0;
      reqQ   <= '0;
    end else if (strobe.flush) begin
      headQ  <= '0;
      countQ <= '0;
      reqQ   <= '0;
    end else begin
      if (popEff) headQ <= headQ + 1'b1;
      countQ <= countQ + CNT_W'(strobe.push) - CNT_W'(popEff);
      for (int i = 0; i < MAX_LINES; i++) begin
        if (strobe.push && tailPtr == PTR_W'(i)) reqQ[i] <= strobe.pushReq;
        else if (strobe.promote && slotMatch[i]) reqQ[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push && !strobe.flush) tagQ[tailPtr] <= pushLine;
  end

  // R12: the record never holds more than MAX_LINES lines
  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNT_W'(MAX_LINES));

  // R12: no push into a full record unless a line leaves at the same time
  p_push_room_r12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> (countQ < CNT_W'(MAX_LINES)) || popEff);

  // R11: a flush empties the record on the next cycle
  p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> countQ == '0);

  // R10: a promotion keeps the line count unchanged
  p_promote_keeps_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.promote && !strobe.pop |=> $stable(countQ));

endmodule

// File: rtl/rpfControl.sv
module rpfControl
  import rpfPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_OFF_W = 6,
  parameter int MAX_LINES = 8,
  parameter int NUM_MASTERS = 8,
  parameter int IPF_W = 3,
  localparam int TAG_W = ADDR_W - LINE_OFF_W,
  localparam int DW_PER_LINE = 1 << (LINE_OFF_W - 2),
  localparam int DWC_W = $clog2(DW_PER_LINE + 1),
  localparam int CNT_W = $clog2(MAX_LINES) + 1,
  localparam int MID_W = $clog2(NUM_MASTERS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [1:0]             reqKind,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [MID_W-1:0]       reqMaster,
  input  logic                   req64,
  input  logic                   reqBurst,
  input  logic                   reqStopEarly,
  input  logic                   lineDone,
  input  logic [NUM_MASTERS-1:0] cfgMasterPfEn,
  input  logic                   cfgPlainPfEn,
  input  logic [IPF_W-1:0]       cfgInitLine,
  input  logic [IPF_W-1:0]       cfgInitMult,
  input  logic                   cfgContLine,
  input  logic                   cfgContMult,
  output logic                   upValid,
  input  logic                   upReady,
  output logic [ADDR_W-1:0]      upAddr,
  output logic [DWC_W-1:0]       upDw,
  output logic                   ack64,
  output logic                   disconnect,
  input  logic                   hit,
  input  logic [CNT_W-1:0]       lineCount,
  output lineStrobeT             strobe,
  output logic [TAG_W-1:0]       pushLine,
  output logic [TAG_W-1:0]       lookupLine
);

  fetchStateT          stateQ;
  logic [ADDR_W-1:0]   startQ;
  logic [DWC_W-1:0]    dwQ;
  logic [CNT_W-1:0]    specLeftQ;
  logic [CNT_W-1:0]    contPendQ;
  logic [TAG_W-1:0]    curLineQ;
  logic [TAG_W-1:0]    lastLineQ;
  logic                burstActQ;
  logic                contEnQ;
  logic                ack64Q;
  logic                discQ;

  logic accept, isPlain, pfEn, isBurst, wide, contSel, fire, popEff, contGo;
  logic [IPF_W-1:0] ipfN;

  assign lookupLine = reqAddr[ADDR_W-1:LINE_OFF_W];
  assign reqReady   = (stateQ == ST_IDLE) && (contPendQ == '0);
  assign accept     = reqValid && reqReady;
  assign isPlain    = (reqKind != KIND_LINE) && (reqKind != KIND_MULT);
  assign pfEn       = cfgMasterPfEn[reqMaster] && (!isPlain || cfgPlainPfEn);
  assign isBurst    = reqBurst || reqStopEarly;
  assign wide       = req64 && (!isPlain || pfEn);
  assign ipfN       = (reqKind == KIND_MULT) ? cfgInitMult : cfgInitLine;
  assign contSel    = (reqKind == KIND_MULT) ? cfgContMult : cfgContLine;
  assign popEff     = lineDone && (lineCount != '0);
  assign contGo     = popEff && burstActQ && contEnQ;

  assign upValid = (stateQ != ST_IDLE);
  assign fire    = upValid && upReady;
  assign upAddr  = (stateQ == ST_SPEC) ? {lastLineQ + TAG_W'(1), LINE_OFF_W'(0)} : startQ;
  assign upDw    = (stateQ == ST_SPEC) ? DWC_W'(DW_PER_LINE) : dwQ;
  assign ack64      = ack64Q;
  assign disconnect = discQ;
  assign pushLine   = (stateQ == ST_FIRST) ? curLineQ : lastLineQ + TAG_W'(1);

  always_comb begin
    strobe         = '0;
    strobe.flush   = accept && !hit;
    strobe.promote = accept && hit;
    strobe.pop     = lineDone;
    strobe.push    = fire && ((stateQ == ST_FIRST) || (stateQ == ST_SPEC));
    strobe.pushReq = (stateQ == ST_FIRST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      startQ    <= '0;
      dwQ       <= '0;
      specLeftQ <= '0;
      contPendQ <= '0;
      curLineQ  <= '0;
      lastLineQ <= '0;
      burstActQ <= 1'b0;
      contEnQ   <= 1'b0;
      ack64Q    <= 1'b0;
      discQ     <= 1'b0;
    end else begin
      discQ <= popEff && (lineCount == CNT_W'(1)) && (stateQ == ST_IDLE)
               && (contPendQ == '0) && !contGo;
      if (accept) begin
        ack64Q    <= wide;
        burstActQ <= pfEn && isBurst;
        contEnQ   <= contSel;
        contPendQ <= CNT_W'(contGo);
        if (!hit) begin
          startQ <= reqAddr & ~ADDR_W'(3);
          if (pfEn && isBurst) begin
            stateQ    <= ST_FIRST;
            dwQ       <= DWC_W'(DW_PER_LINE) - DWC_W'(reqAddr[LINE_OFF_W-1:2]);
            specLeftQ <= CNT_W'(ipfN);
            curLineQ  <= lookupLine;
          end else begin
            stateQ <= ST_SINGLE;
            dwQ    <= wide ? DWC_W'(2) : DWC_W'(1);
          end
        end
      end else begin
        contPendQ <= contPendQ + CNT_W'(contGo);
        case (stateQ)
          ST_IDLE: if (contPendQ != '0) begin
            stateQ    <= ST_SPEC;
            specLeftQ <= contPendQ;
            contPendQ <= CNT_W'(contGo);
          end
          ST_SINGLE: if (upReady) stateQ <= ST_IDLE;
          ST_FIRST: if (upReady) begin
            lastLineQ <= curLineQ;
            stateQ    <= (specLeftQ == '0) ? ST_IDLE : ST_SPEC;
          end
          ST_SPEC: if (upReady) begin
            lastLineQ <= lastLineQ + TAG_W'(1);
            if (specLeftQ == CNT_W'(1)) stateQ <= ST_IDLE;
            else specLeftQ <= specLeftQ - CNT_W'(1);
          end
          default: stateQ <= ST_IDLE;
        endcase
      end
    end
  end

  // R2: plain read without prefetch never acknowledges 64-bit
  p_plain_no_ack_r2: assert property (@(posedge clk) disable iff (!rstN)
    accept && isPlain && !pfEn |=> !ack64);

  // R14: a stalled upstream request holds steady
  p_hold_stall_r14: assert property (@(posedge clk) disable iff (!rstN)
    upValid && !upReady |=> upValid && $stable(upAddr) && $stable(upDw));

  // R8: multi-dword line requests only while a prefetching burst is active
  p_spec_needs_burst_r8: assert property (@(posedge clk) disable iff (!rstN)
    upValid && (upDw > DWC_W'(2)) |-> burstActQ);

  // R5: the first burst request ends exactly at the line boundary
  p_first_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    upValid && (stateQ == ST_FIRST) |->
      (DWC_W'(upAddr[LINE_OFF_W-1:2]) + upDw) == DWC_W'(DW_PER_LINE));

  // R13: disconnect is a single-cycle pulse
  p_disc_pulse_r13: assert property (@(posedge clk) disable iff (!rstN)
    disconnect |=> !disconnect);

endmodule

// File: rtl/readPrefetchCtl.sv
module readPrefetchCtl
  import rpfPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_OFF_W = 6,
  parameter int MAX_LINES = 8,
  parameter int NUM_MASTERS = 8,
  parameter int IPF_W = 3,
  localparam int TAG_W = ADDR_W - LINE_OFF_W,
  localparam int DWC_W = $clog2((1 << (LINE_OFF_W - 2)) + 1),
  localparam int CNT_W = $clog2(MAX_LINES) + 1,
  localparam int MID_W = $clog2(NUM_MASTERS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [1:0]             reqKind,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [MID_W-1:0]       reqMaster,
  input  logic                   req64,
  input  logic                   reqBurst,
  input  logic                   reqStopEarly,
  input  logic                   lineDone,
  input  logic [NUM_MASTERS-1:0] cfgMasterPfEn,
  input  logic                   cfgPlainPfEn,
  input  logic [IPF_W-1:0]       cfgInitLine,
  input  logic [IPF_W-1:0]       cfgInitMult,
  input  logic                   cfgContLine,
  input  logic                   cfgContMult,
  output logic                   upValid,
  input  logic                   upReady,
  output logic [ADDR_W-1:0]      upAddr,
  output logic [DWC_W-1:0]       upDw,
  output logic                   ack64,
  output logic                   disconnect,
  output logic [CNT_W-1:0]       lineCount,
  output logic [MAX_LINES-1:0]   lineReqMask
);

  lineStrobeT       strobe;
  logic [TAG_W-1:0] pushLine;
  logic [TAG_W-1:0] lookupLine;
  logic             hit;

  rpfControl #(
    .ADDR_W(ADDR_W), .LINE_OFF_W(LINE_OFF_W), .MAX_LINES(MAX_LINES),
    .NUM_MASTERS(NUM_MASTERS), .IPF_W(IPF_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqMaster(reqMaster), .req64(req64),
    .reqBurst(reqBurst), .reqStopEarly(reqStopEarly), .lineDone(lineDone),
    .cfgMasterPfEn(cfgMasterPfEn), .cfgPlainPfEn(cfgPlainPfEn),
    .cfgInitLine(cfgInitLine), .cfgInitMult(cfgInitMult),
    .cfgContLine(cfgContLine), .cfgContMult(cfgContMult),
    .upValid(upValid), .upReady(upReady), .upAddr(upAddr), .upDw(upDw),
    .ack64(ack64), .disconnect(disconnect),
    .hit(hit), .lineCount(lineCount),
    .strobe(strobe), .pushLine(pushLine), .lookupLine(lookupLine)
  );

  rpfLineTrack #(
    .TAG_W(TAG_W), .MAX_LINES(MAX_LINES)
  ) u_lines (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .pushLine(pushLine), .lookupLine(lookupLine),
    .hit(hit), .lineCount(lineCount), .reqMask(lineReqMask)
  );

endmodule

// File: tb/readPrefetchCtl_tb.sv
`timescale 1ns/1ps
module readPrefetchCtl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqKind = '0;
  logic [31:0] reqAddr = '0;
  logic [2:0]  reqMaster = '0;
  logic        req64 = 1'b0;
  logic        reqBurst = 1'b0;
  logic        reqStopEarly = 1'b0;
  logic        lineDone = 1'b0;
  logic [7:0]  cfgMasterPfEn = 8'hFD;
  logic        cfgPlainPfEn = 1'b0;
  logic [2:0]  cfgInitLine = '0;
  logic [2:0]  cfgInitMult = '0;
  logic        cfgContLine = 1'b0;
  logic        cfgContMult = 1'b0;
  logic        upValid;
  logic        upReady = 1'b1;
  logic [31:0] upAddr;
  logic [4:0]  upDw;
  logic        ack64;
  logic        disconnect;
  logic [3:0]  lineCount;
  logic [7:0]  lineReqMask;

  int checks = 0;
  int fails = 0;
  logic [31:0] expAddrQ[$];
  logic [4:0]  expDwQ[$];
  string       expTagQ[$];

  always #2 clk = ~clk;

  readPrefetchCtl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqAddr(reqAddr), .reqMaster(reqMaster), .req64(req64),
    .reqBurst(reqBurst), .reqStopEarly(reqStopEarly), .lineDone(lineDone),
    .cfgMasterPfEn(cfgMasterPfEn), .cfgPlainPfEn(cfgPlainPfEn),
    .cfgInitLine(cfgInitLine), .cfgInitMult(cfgInitMult),
    .cfgContLine(cfgContLine), .cfgContMult(cfgContMult),
    .upValid(upValid), .upReady(upReady), .upAddr(upAddr), .upDw(upDw),
    .ack64(ack64), .disconnect(disconnect), .lineCount(lineCount),
    .lineReqMask(lineReqMask)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic expectUp(input logic [31:0] a, input logic [4:0] dw, input string tag);
    expAddrQ.push_back(a);
    expDwQ.push_back(dw);
    expTagQ.push_back(tag);
  endtask

  // monitor: one comparison per accepted upstream request
  always @(negedge clk) begin
    if (rstN && upValid && upReady) begin
      if (expAddrQ.size() == 0) begin
        chk(1'b0, "R8", "unexpected upstream addr", upAddr, 0);
      end else begin
        logic [31:0] ea;
        logic [4:0]  ed;
        string       et;
        ea = expAddrQ.pop_front();
        ed = expDwQ.pop_front();
        et = expTagQ.pop_front();
        chk(upAddr == ea, et, "upstream addr", upAddr, ea);
        chk(upDw == ed, et, "upstream dwords", upDw, ed);
      end
    end
  end

  task automatic issue(input logic [1:0] kind, input logic [31:0] a,
                       input logic [2:0] m, input bit r64, input bit burst,
                       input bit stopEarly);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqKind = kind; reqAddr = a; reqMaster = m; req64 = r64;
    reqBurst = burst; reqStopEarly = stopEarly; reqValid = 1'b1;
    @(posedge clk); #1 reqValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain();
    @(negedge clk);
    while (!(expAddrQ.size() == 0 && reqReady && !upValid)) @(negedge clk);
  endtask

  task automatic retireLine();
    @(posedge clk); #1 lineDone = 1'b1;
    @(posedge clk); #1 lineDone = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R14 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(lineCount == 0 && !upValid && !ack64 && !disconnect && reqReady,
        "R12", "reset state", {lineCount, upValid, ack64, disconnect, reqReady}, 1);

    // R2: plain read, master enabled but plain enable off, 64-bit asked
    expectUp(32'h0000_0104, 5'd1, "R2");
    issue(2'd0, 32'h0000_0104, 3'd0, 1'b1, 1'b1, 1'b0);
    chk(!ack64, "R2", "ack64 for plain without prefetch", ack64, 0);
    drain();
    chk(lineCount == 0, "R8", "no lines for non-prefetch read", lineCount, 0);

    // R1/R3: read-line from master 1 (disabled) is not prefetched
    expectUp(32'h0000_0208, 5'd2, "R1");
    issue(2'd1, 32'h0000_0208, 3'd1, 1'b1, 1'b1, 1'b0);
    chk(ack64, "R3", "ack64 for read-line without prefetch", ack64, 1);
    drain();
    expectUp(32'h0000_0300, 5'd1, "R3");
    issue(2'd1, 32'h0000_0300, 3'd1, 1'b0, 1'b1, 1'b0);
    chk(!ack64, "R3", "ack64 with 32-bit request", ack64, 0);
    drain();

    // R3/R8: prefetch enabled but not a burst
    cfgInitMult = 3'd5;
    expectUp(32'h0000_0400, 5'd2, "R3");
    issue(2'd2, 32'h0000_0400, 3'd0, 1'b1, 1'b0, 1'b0);
    chk(ack64, "R3", "ack64 for non-burst enabled read", ack64, 1);
    drain();
    chk(lineCount == 0, "R8", "no lines without burst", lineCount, 0);

    // R5/R6/R14: read-line burst with stall on the first request
    cfgInitLine = 3'd2;
    upReady = 1'b0;
    expectUp(32'h1000_0024, 5'd7, "R5");
    expectUp(32'h1000_0040, 5'd16, "R6");
    expectUp(32'h1000_0080, 5'd16, "R6");
    issue(2'd1, 32'h1000_0026, 3'd0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      chk(upValid && upAddr == 32'h1000_0024 && upDw == 5'd7, "R14",
          "stalled request", upAddr, 32'h1000_0024);
      @(negedge clk);
    end
    @(posedge clk); #1 upReady = 1'b1;
    drain();
    chk(lineCount == 3, "R12", "lines after burst", lineCount, 3);
    chk(lineReqMask == 8'h01, "R9", "requested tags", lineReqMask, 8'h01);

    // R4/R11/R1: plain burst flagged only by early stop, plain enable on
    cfgPlainPfEn = 1'b1;
    cfgInitLine  = 3'd1;
    expectUp(32'h2000_0000, 5'd16, "R4");
    expectUp(32'h2000_0040, 5'd16, "R6");
    issue(2'd0, 32'h2000_0000, 3'd0, 1'b0, 1'b0, 1'b1);
    chk(lineCount == 0, "R11", "flush on miss", lineCount, 0);
    drain();
    chk(lineCount == 2 && lineReqMask == 8'h01, "R9", "plain burst lines",
        {lineCount, lineReqMask}, {4'd2, 8'h01});

    // R10: fresh address phase inside the speculative line
    issue(2'd1, 32'h2000_0048, 3'd0, 1'b0, 1'b1, 1'b0);
    chk(!upValid, "R10", "no upstream on hit", upValid, 0);
    chk(lineReqMask == 8'h03 && lineCount == 2, "R10", "promotion",
        {lineCount, lineReqMask}, {4'd2, 8'h03});
    drain();

    // R6/R12: read-multiple fills eight lines
    cfgInitMult = 3'd7;
    cfgContMult = 1'b1;
    expectUp(32'h3000_0000, 5'd16, "R6");
    for (int i = 1; i < 8; i++) expectUp(32'h3000_0000 + 32'(i) * 64, 5'd16, "R6");
    issue(2'd2, 32'h3000_0000, 3'd0, 1'b1, 1'b1, 1'b0);
    drain();
    chk(lineCount == 8, "R12", "full record", lineCount, 8);

    // R7/R9: retiring a line triggers one continuous fetch, no promotion
    expectUp(32'h3000_0200, 5'd16, "R7");
    retireLine();
    chk(!disconnect, "R13", "no disconnect with more lines", disconnect, 0);
    drain();
    chk(lineCount == 8, "R7", "lines after continuous fetch", lineCount, 8);
    chk(lineReqMask == 8'h00, "R9", "burst into line keeps tag", lineReqMask, 8'h00);

    // R13: single line, no continuous prefetch, then disconnect
    cfgInitLine = 3'd0;
    cfgContLine = 1'b0;
    expectUp(32'h4000_0000, 5'd16, "R5");
    issue(2'd1, 32'h4000_0000, 3'd0, 1'b0, 1'b1, 1'b0);
    drain();
    chk(lineCount == 1, "R12", "single line", lineCount, 1);
    retireLine();
    chk(disconnect && lineCount == 0, "R13", "disconnect pulse",
        {disconnect, lineCount}, {1'b1, 4'd0});
    @(negedge clk);
    chk(!disconnect, "R13", "disconnect drops", disconnect, 0);

    repeat (4) @(negedge clk);
    chk(expAddrQ.size() == 0, "R8", "pending expected requests", expAddrQ.size(), 0);
    summary();
    $finish;
  end

endmodule